// File: doc/BRIEF.md
# CPU Interrupt Control Unit

This block keeps the interrupt state of a small 8-bit processor core. It holds two enable flags: a live enable that gates maskable requests, and a saved copy that is kept across a non-maskable service. It also holds the interrupt mode register. At each opcode-fetch strobe from the sequencer, it decides whether a pending non-maskable request or a maskable request is taken. Vector fetch and stack handling are done elsewhere.

The sequencer drives plain control strobes: a flag write with a value bit and a "both flags" select, a mode write with a 2-bit code, the fetch strobe, and an inhibit level. The raw request lines come straight from the pins. The outputs are the saved enable flag, two decoded mode flags, and a one-cycle acceptance pulse for each request type. All pins are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the live enable, `ena_saved`, `mode1`, `mode2`, `nmi_taken` and `int_taken` are all 0.
- R2: A mode write decodes `mode_code` as follows: 2'b10 gives `mode1`=1 and `mode2`=0; 2'b11 gives `mode2`=1 and `mode1`=0; 2'b00 and 2'b01 give both outputs 0.
- R3: The mode outputs change at the clock edge where `mode_we` is high. While `mode_we` is low they hold their value, whatever `mode_code` carries.
- R4: A flag write with `ief_both`=1 and `ief_val`=1 sets `ena_saved` at that edge. It sets the live enable one edge later, so a maskable request sampled at the very next fetch is still refused.
- R5: A flag write with `ief_both`=0 sets the live enable to `ief_val` at once and leaves `ena_saved` unchanged.
- R6: A flag write with `ief_both`=1 and `ief_val`=0 clears both flags at the same edge.
- R7: A rising edge on `nmi_req` is held as pending until the next edge with `m1_start` high. At that edge `nmi_taken` pulses high for one cycle. A level that stays high does not trigger again.
- R8: Taking a non-maskable request clears the live enable and leaves `ena_saved` unchanged.
- R9: A maskable request (`int_req` high) is taken at a fetch edge only when the live enable is 1, `irq_block` is low and no non-maskable request is pending. When it is taken, `int_taken` pulses for one cycle and both flags clear. An acceptance overrides a flag write in the same cycle.
- R10: When both request types are ready at the same fetch, only the non-maskable one is taken.
- R11: While `irq_block` is high, maskable requests are refused. Non-maskable requests are still taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ief_we | input | 1 | Enable-flag write strobe |
| ief_val | input | 1 | Value written to the flag(s) |
| ief_both | input | 1 | 1: write both flags; 0: write the live enable only |
| mode_we | input | 1 | Mode register write strobe |
| mode_code | input | 2 | Mode code written on `mode_we` |
| m1_start | input | 1 | Opcode-fetch strobe; requests are taken here |
| irq_block | input | 1 | Inhibits acceptance of maskable requests |
| nmi_req | input | 1 | Raw non-maskable request, edge-sensitive |
| int_req | input | 1 | Raw maskable request, level-sensitive |
| ena_saved | output | 1 | Saved enable flag |
| mode1 | output | 1 | Mode 1 selected |
| mode2 | output | 1 | Mode 2 selected |
| nmi_taken | output | 1 | One-cycle pulse: non-maskable request taken |
| int_taken | output | 1 | One-cycle pulse: maskable request taken |

## Verification
The live enable flag is not a port. Its value, including the one-cycle lag after an enable write, can only be seen through whether a maskable request is taken at a fetch. The bench therefore holds `int_req` and `m1_start` high in the cycle right after the enable write, and expects a refusal. It then expects an acceptance one cycle later. Every flag write and every NMI scenario is followed by the same probe, which shows the hidden flag's state without reading internals.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    MODE_0 = 2'd0,
    MODE_1 = 2'd1,
    MODE_2 = 2'd2
  } irq_mode_t;

  localparam logic [1:0] CODE_M1 = 2'b10;
  localparam logic [1:0] CODE_M2 = 2'b11;

  function automatic irq_mode_t decode_mode(input logic [1:0] code);
    case (code)
      CODE_M1: return MODE_1;
      CODE_M2: return MODE_2;
      default: return MODE_0;
    endcase
  endfunction
endpackage

// File: rtl/irq_mode_reg.sv
module irq_mode_reg
  import irq_pkg::*;
#(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CODE_W-1:0] code,
  output logic              mode1_o,
  output logic              mode2_o
);
  irq_mode_t mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mode_q <= MODE_0;
    else if (we) mode_q <= decode_mode(code[1:0]);
  end

  assign mode1_o = (mode_q == MODE_1);
  assign mode2_o = (mode_q == MODE_2);

  assert_mode1_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && code[1:0] == CODE_M1) |=> (mode1_o && !mode2_o));
  assert_mode2_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && code[1:0] == CODE_M2) |=> (mode2_o && !mode1_o));
  assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable({mode1_o, mode2_o}));
endmodule

// File: rtl/irq_enable_flags.sv
module irq_enable_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ief_we,
  input  logic ief_val,
  input  logic ief_both,
  input  logic acc_nmi,
  input  logic acc_int,
  output logic live_en,
  output logic saved_en
);
  logic f1_q, f2_q, arm_q;
  logic f1_n, f2_n, arm_n;

  always_comb begin
    f1_n  = arm_q ? 1'b1 : f1_q;
    f2_n  = f2_q;
    arm_n = 1'b0;
    if (acc_int) begin
      f1_n = 1'b0;
      f2_n = 1'b0;
    end else if (acc_nmi) begin
      f1_n = 1'b0;
    end else if (ief_we) begin
      if (ief_both) begin
        f2_n = ief_val;
        if (ief_val) arm_n = 1'b1;
        else         f1_n  = 1'b0;
      end else begin
        f1_n = ief_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f1_q  <= 1'b0;
      f2_q  <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      f1_q  <= f1_n;
      f2_q  <= f2_n;
      arm_q <= arm_n;
    end
  end

  assign live_en  = f1_q;
  assign saved_en = f2_q;

  assert_saved_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ief_we && ief_both && ief_val && !acc_int && !acc_nmi) |=> saved_en);
  assert_live_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ief_we && ief_both && ief_val && !acc_int && !acc_nmi && !live_en) |=> !live_en);
  assert_nmi_keeps_saved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_nmi && !acc_int) |=> (!live_en && saved_en == $past(saved_en)));
  assert_int_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_int |=> (!live_en && !saved_en));
  assert_both_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ief_we && ief_both && !ief_val) |=> (!live_en && !saved_en));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic m1_start,
  input  logic irq_block,
  input  logic nmi_req,
  input  logic int_req,
  input  logic live_en,
  output logic acc_nmi,
  output logic acc_int,
  output logic nmi_taken,
  output logic int_taken
);
  logic nmi_prev_q, nmi_pend_q;

  assign acc_nmi = m1_start && nmi_pend_q;
  assign acc_int = m1_start && int_req && live_en && !irq_block && !nmi_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev_q <= 1'b0;
      nmi_pend_q <= 1'b0;
      nmi_taken  <= 1'b0;
      int_taken  <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_req;
      nmi_pend_q <= (nmi_pend_q && !acc_nmi) || (nmi_req && !nmi_prev_q);
      nmi_taken  <= acc_nmi;
      int_taken  <= acc_int;
    end
  end

  assert_nmi_at_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_taken |-> $past(m1_start));
  assert_nmi_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_taken |-> !int_taken);
  assert_block_int_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m1_start && irq_block) |=> !int_taken);
  assert_int_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m1_start && !live_en) |=> !int_taken);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ief_we,
  input  logic              ief_val,
  input  logic              ief_both,
  input  logic              mode_we,
  input  logic [CODE_W-1:0] mode_code,
  input  logic              m1_start,
  input  logic              irq_block,
  input  logic              nmi_req,
  input  logic              int_req,
  output logic              ena_saved,
  output logic              mode1,
  output logic              mode2,
  output logic              nmi_taken,
  output logic              int_taken
);
  logic live_en, acc_nmi, acc_int;

  irq_mode_reg #(.CODE_W(CODE_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .we(mode_we), .code(mode_code),
    .mode1_o(mode1), .mode2_o(mode2)
  );

  irq_enable_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ief_we(ief_we), .ief_val(ief_val),
    .ief_both(ief_both), .acc_nmi(acc_nmi), .acc_int(acc_int),
    .live_en(live_en), .saved_en(ena_saved)
  );

  irq_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .m1_start(m1_start), .irq_block(irq_block),
    .nmi_req(nmi_req), .int_req(int_req), .live_en(live_en),
    .acc_nmi(acc_nmi), .acc_int(acc_int),
    .nmi_taken(nmi_taken), .int_taken(int_taken)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!ena_saved && !mode1 && !mode2 && !nmi_taken && !int_taken));
endmodule

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ief_we = 0, ief_val = 0, ief_both = 0, mode_we = 0;
  logic [1:0] mode_code = 2'b00;
  logic m1_start = 0, irq_block = 0, nmi_req = 0, int_req = 0;
  logic ena_saved, mode1, mode2, nmi_taken, int_taken;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ief_we(ief_we), .ief_val(ief_val),
    .ief_both(ief_both), .mode_we(mode_we), .mode_code(mode_code),
    .m1_start(m1_start), .irq_block(irq_block), .nmi_req(nmi_req),
    .int_req(int_req), .ena_saved(ena_saved), .mode1(mode1), .mode2(mode2),
    .nmi_taken(nmi_taken), .int_taken(int_taken)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic enable_all();
    ief_we = 1; ief_both = 1; ief_val = 1; tick();
    ief_we = 0; ief_both = 0; ief_val = 0; tick();
  endtask

  task automatic fetch_int(string req, logic exp);
    int_req = 1; m1_start = 1; tick();
    check(req, int_taken, exp);
    int_req = 0; m1_start = 0; tick();
  endtask

  task automatic t_reset();
    tick(); tick();
    check("R1 saved", ena_saved, 0); check("R1 mode1", mode1, 0);
    check("R1 mode2", mode2, 0); check("R1 nmi", nmi_taken, 0);
    check("R1 int", int_taken, 0);
    rst_n = 1; tick();
    check("R1 saved after", ena_saved, 0);
    fetch_int("R1 live enable 0", 0);
  endtask

  task automatic t_modes();
    mode_we = 1; mode_code = 2'b10; tick();
    check("R2 10 mode1", mode1, 1); check("R2 10 mode2", mode2, 0);
    mode_code = 2'b11; tick();
    check("R2 11 mode1", mode1, 0); check("R2 11 mode2", mode2, 1);
    mode_code = 2'b01; tick();
    check("R2 01 mode1", mode1, 0); check("R2 01 mode2", mode2, 0);
    mode_code = 2'b10; tick();
    mode_we = 0; mode_code = 2'b11; tick(); tick();
    check("R3 hold mode1", mode1, 1); check("R3 hold mode2", mode2, 0);
    mode_we = 1; mode_code = 2'b00; tick();
    check("R2 00 mode1", mode1, 0); check("R2 00 mode2", mode2, 0);
    mode_we = 0;
  endtask

  task automatic t_enable_lag();
    ief_we = 1; ief_both = 1; ief_val = 1; tick();
    check("R4 saved at once", ena_saved, 1);
    ief_we = 0; ief_both = 0; ief_val = 0;
    int_req = 1; m1_start = 1; tick();
    check("R4 live lags one cycle", int_taken, 0);
    tick();
    check("R4 live set / R9 taken", int_taken, 1);
    check("R9 saved cleared", ena_saved, 0);
    int_req = 0; m1_start = 0; tick();
    check("R9 pulse one cycle", int_taken, 0);
    fetch_int("R9 live cleared", 0);
  endtask

  task automatic t_live_only();
    enable_all();
    ief_we = 1; ief_both = 0; ief_val = 0; tick();
    check("R5 saved kept", ena_saved, 1);
    ief_we = 0;
    fetch_int("R5 live cleared", 0);
    ief_we = 1; ief_both = 0; ief_val = 1; tick();
    ief_we = 0; ief_val = 0;
    fetch_int("R5 live set at once", 1);
  endtask

  task automatic t_clear_both();
    enable_all();
    ief_we = 1; ief_both = 1; ief_val = 0; tick();
    check("R6 saved cleared", ena_saved, 0);
    ief_we = 0; ief_both = 0;
    fetch_int("R6 live cleared", 0);
  endtask

  task automatic t_nmi();
    enable_all();
    nmi_req = 1; tick(); tick();
    check("R7 waits for fetch", nmi_taken, 0);
    m1_start = 1; tick();
    check("R7 nmi taken", nmi_taken, 1);
    check("R8 saved kept", ena_saved, 1);
    m1_start = 0; tick();
    check("R7 pulse one cycle", nmi_taken, 0);
    fetch_int("R8 live cleared", 0);
    m1_start = 1; tick();
    check("R7 level no retrigger", nmi_taken, 0);
    m1_start = 0; nmi_req = 0; tick();
  endtask

  task automatic t_priority();
    enable_all();
    nmi_req = 1; tick(); nmi_req = 0;
    int_req = 1; m1_start = 1; tick();
    check("R10 nmi wins", nmi_taken, 1);
    check("R10 int refused", int_taken, 0);
    int_req = 0; m1_start = 0; tick();
  endtask

  task automatic t_block();
    enable_all();
    irq_block = 1; int_req = 1; m1_start = 1; tick();
    check("R11 int blocked", int_taken, 0);
    irq_block = 0; tick();
    check("R11 int after unblock", int_taken, 1);
    int_req = 0; m1_start = 0; tick();
    nmi_req = 1; tick(); nmi_req = 0;
    irq_block = 1; m1_start = 1; tick();
    check("R11 nmi ignores block", nmi_taken, 1);
    irq_block = 0; m1_start = 0; tick();
  endtask

  initial begin
    t_reset();
    t_modes();
    t_enable_lag();
    t_live_only();
    t_clear_both();
    t_nmi();
    t_priority();
    t_block();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule